// File: doc/BRIEF.md
# Multi-Hart Debug Request and Acknowledge Register Bank

This block is the mailbox between a debug controller and up to four CPU harts. The debug side pulses a resume or execute request for one hart. The block keeps that request as a sticky flag until the hart answers it. A hart reads its flags over a simple single-cycle bus. Each hart owns one byte lane of the word at the window base, so a hart can load an unsigned byte at base plus its own hart ID and see only its own flags.

Reads and writes at the same address do different things. A hart acknowledges an event by writing a word to one of four word-aligned slots in the 16-byte window: halt, resume, execute or exception. For the first three slots, the write data carries the encoded hart ID and not a bit mask. Every such write becomes a single-cycle pulse toward the debug side. A resume or execute acknowledge also clears the matching flag of that hart.

Top module: `dbg_req_ack_regs`

## Requirements
- R1: The window covers byte addresses 0xFFFFFF80 to 0xFFFFFF8F. An access outside it gets no bus acknowledge, reads as zero and changes no flag and no acknowledge output.
- R2: Every access inside the window is acknowledged on bus_ack_o in the cycle after the request, with no wait states, and bus_rdata_o is valid in that same cycle.
- R3: A read of any byte address in 0xFFFFFF80 to 0xFFFFFF83 returns the same word. For each hart n, bit 8n is its resume flag and bit 8n+1 is its execute flag. All other bits are zero. When no read is being answered, bus_rdata_o is zero.
- R4: Reads at offsets 4, 8 and 12 return zero.
- R5: A one-cycle pulse on dm_resume_req_i[n] sets the resume flag of hart n. The flag stays set until a resume acknowledge for hart n is written.
- R6: A one-cycle pulse on dm_exec_req_i[n] sets the execute flag of hart n. The flag stays set until an execute acknowledge for hart n is written.
- R7: A write at offset 0 raises dm_halt_ack_o[id] for exactly one cycle, in the cycle after the write, where id is write data bits 1:0. No flag changes.
- R8: A write at offset 4 raises dm_resume_ack_o[id] for one cycle and clears only the resume flag of hart id.
- R9: A write at offset 8 raises dm_exec_ack_o[id] for one cycle and clears only the execute flag of hart id.
- R10: A write of any data at offset 12 raises dm_exc_ack_o for one cycle. At most one acknowledge output is high in any cycle.
- R11: If a request pulse and the matching acknowledge for the same hart arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data; bits 1:0 carry the hart ID |
| bus_ack_o | output | 1 | Access completed (cycle after request) |
| bus_rdata_o | output | 32 | Read data, valid with bus_ack_o |
| dm_resume_req_i | input | 4 | Per-hart resume request pulse |
| dm_exec_req_i | input | 4 | Per-hart execute request pulse |
| dm_halt_ack_o | output | 4 | Per-hart halt acknowledge pulse |
| dm_resume_ack_o | output | 4 | Per-hart resume acknowledge pulse |
| dm_exec_ack_o | output | 4 | Per-hart execute acknowledge pulse |
| dm_exc_ack_o | output | 1 | Exception acknowledge pulse |

## Verification
The hardest case to reach is a request pulse and the acknowledge write for the same hart landing on the same clock edge, which checks that the set wins. The stimulus drives the request pulse and the bus write in one driver call, so both share a cycle by construction. A read follows to show that the flag survived. Writes that fall just outside the window carry hart IDs whose flags are set, so a decode that leaks would show up as a cleared flag on the next read.

// File: rtl/dbgrq_pkg.sv
package dbgrq_pkg;

    // Word slot inside the 16-byte window, taken from address bits 3:2
    typedef enum logic [1:0] {
        SLOT_HALT   = 2'd0,
        SLOT_RESUME = 2'd1,
        SLOT_EXEC   = 2'd2,
        SLOT_EXC    = 2'd3
    } slot_e;

    typedef struct packed {
        logic  rd;
        logic  wr;
        slot_e slot;
    } dec_t;

endpackage

// File: rtl/dbgrq_decode.sv
module dbgrq_decode
    import dbgrq_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FF80
) (
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output dec_t              dec_o
);
    localparam int OFS_W = 4;

    always_comb begin
        hit_o      = req_i && (addr_i[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
        dec_o.rd   = hit_o && !we_i;
        dec_o.wr   = hit_o && we_i;
        dec_o.slot = slot_e'(addr_i[3:2]);
    end

endmodule

// File: rtl/dbgrq_flags.sv
module dbgrq_flags #(
    parameter int NUM_HARTS = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_HARTS-1:0] set_res_i,
    input  logic [NUM_HARTS-1:0] set_exe_i,
    input  logic [NUM_HARTS-1:0] clr_res_i,
    input  logic [NUM_HARTS-1:0] clr_exe_i,
    output logic [NUM_HARTS-1:0] res_o,
    output logic [NUM_HARTS-1:0] exe_o
);
    typedef struct packed {
        logic [NUM_HARTS-1:0] res;
        logic [NUM_HARTS-1:0] exe;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // clear first, then set: a simultaneous request keeps the flag
        st_d.res = (st_q.res & ~clr_res_i) | set_res_i;
        st_d.exe = (st_q.exe & ~clr_exe_i) | set_exe_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign res_o = st_q.res;
    assign exe_o = st_q.exe;

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_chk
        assert_res_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_res_i[i] |=> res_o[i]);
        assert_res_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (res_o[i] && !clr_res_i[i]) |=> res_o[i]);
        assert_exe_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_exe_i[i] |=> exe_o[i]);
        assert_exe_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (exe_o[i] && !clr_exe_i[i]) |=> exe_o[i]);
        assert_res_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_res_i[i] && !set_res_i[i]) |=> !res_o[i]);
        assert_exe_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_exe_i[i] && !set_exe_i[i]) |=> !exe_o[i]);
        assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (set_res_i[i] && clr_res_i[i]) |=> res_o[i]);
    end

endmodule

// File: rtl/dbgrq_ackgen.sv
module dbgrq_ackgen
    import dbgrq_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int DATA_W    = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  slot_e                slot_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [NUM_HARTS-1:0] clr_res_o,
    output logic [NUM_HARTS-1:0] clr_exe_o,
    output logic [NUM_HARTS-1:0] halt_ack_o,
    output logic [NUM_HARTS-1:0] res_ack_o,
    output logic [NUM_HARTS-1:0] exe_ack_o,
    output logic                 exc_ack_o
);
    localparam int HID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    typedef struct packed {
        logic [NUM_HARTS-1:0] halt;
        logic [NUM_HARTS-1:0] res;
        logic [NUM_HARTS-1:0] exe;
        logic                 exc;
    } ack_t;

    ack_t                 ack_d, ack_q;
    logic [NUM_HARTS-1:0] sel;

    // encoded hart ID in the write data -> one-hot hart select
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_HARTS; i++) begin
            if (wdata_i[HID_W-1:0] == HID_W'(i)) sel[i] = 1'b1;
        end
    end

    always_comb begin
        ack_d = '0;
        if (wr_i) begin
            unique case (slot_i)
                SLOT_HALT:   ack_d.halt = sel;
                SLOT_RESUME: ack_d.res  = sel;
                SLOT_EXEC:   ack_d.exe  = sel;
                SLOT_EXC:    ack_d.exc  = 1'b1;
                default:     ack_d      = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ack_q <= '0;
        else         ack_q <= ack_d;
    end

    assign clr_res_o  = (wr_i && slot_i == SLOT_RESUME) ? sel : '0;
    assign clr_exe_o  = (wr_i && slot_i == SLOT_EXEC)   ? sel : '0;
    assign halt_ack_o = ack_q.halt;
    assign res_ack_o  = ack_q.res;
    assign exe_ack_o  = ack_q.exe;
    assign exc_ack_o  = ack_q.exc;

    assert_single_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({halt_ack_o, res_ack_o, exe_ack_o, exc_ack_o}));
    assert_exc_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_ack_o |-> $past(wr_i && slot_i == SLOT_EXC));
    assert_halt_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|halt_ack_o) |-> $past(wr_i && slot_i == SLOT_HALT));
    assert_no_write_no_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> !(|{halt_ack_o, res_ack_o, exe_ack_o, exc_ack_o}));

endmodule

// File: rtl/dbg_req_ack_regs.sv
module dbg_req_ack_regs
    import dbgrq_pkg::*;
#(
    parameter int                NUM_HARTS = 4,
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FF80
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_req_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic                 bus_ack_o,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic [NUM_HARTS-1:0] dm_resume_req_i,
    input  logic [NUM_HARTS-1:0] dm_exec_req_i,
    output logic [NUM_HARTS-1:0] dm_halt_ack_o,
    output logic [NUM_HARTS-1:0] dm_resume_ack_o,
    output logic [NUM_HARTS-1:0] dm_exec_ack_o,
    output logic                 dm_exc_ack_o
);
    localparam int LANE_W = 8;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } bus_t;

    logic                 hit;
    dec_t                 dec;
    logic [NUM_HARTS-1:0] res_flags, exe_flags, clr_res, clr_exe;
    logic [DATA_W-1:0]    image;
    bus_t                 bus_d, bus_q;

    dbgrq_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .req_i  (bus_req_i),
        .we_i   (bus_we_i),
        .addr_i (bus_addr_i),
        .hit_o  (hit),
        .dec_o  (dec)
    );

    dbgrq_ackgen #(.NUM_HARTS(NUM_HARTS), .DATA_W(DATA_W)) u_ackgen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (dec.wr),
        .slot_i     (dec.slot),
        .wdata_i    (bus_wdata_i),
        .clr_res_o  (clr_res),
        .clr_exe_o  (clr_exe),
        .halt_ack_o (dm_halt_ack_o),
        .res_ack_o  (dm_resume_ack_o),
        .exe_ack_o  (dm_exec_ack_o),
        .exc_ack_o  (dm_exc_ack_o)
    );

    dbgrq_flags #(.NUM_HARTS(NUM_HARTS)) u_flags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_res_i (dm_resume_req_i),
        .set_exe_i (dm_exec_req_i),
        .clr_res_i (clr_res),
        .clr_exe_i (clr_exe),
        .res_o     (res_flags),
        .exe_o     (exe_flags)
    );

    // one byte lane per hart: bit 0 resume, bit 1 execute
    always_comb begin
        image = '0;
        for (int i = 0; i < NUM_HARTS; i++) begin
            image[i*LANE_W +: 2] = {exe_flags[i], res_flags[i]};
        end
    end

    always_comb begin
        bus_d       = '0;
        bus_d.ack   = hit;
        if (dec.rd && dec.slot == SLOT_HALT) bus_d.rdata = image;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bus_q <= '0;
        else         bus_q <= bus_d;
    end

    assign bus_ack_o   = bus_q.ack;
    assign bus_rdata_o = bus_q.rdata;

    assert_ack_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> bus_ack_o);
    assert_outside_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit |=> !bus_ack_o);
    assert_idle_rdata_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_ack_o |-> (bus_rdata_o == '0));
    assert_upper_slots_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec.rd && dec.slot != SLOT_HALT) |=> (bus_rdata_o == '0));

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_lane_chk
        assert_lane_unused_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            bus_rdata_o[i*LANE_W+2 +: LANE_W-2] == '0);
    end

endmodule

// File: tb/dbg_req_ack_regs_test.sv
module dbg_req_ack_regs_test;

    localparam logic [31:0] BASE = 32'hFFFF_FF80;

    typedef struct {
        logic        ack;
        logic [31:0] rdata;
        logic [3:0]  halt;
        logic [3:0]  res;
        logic [3:0]  exe;
        logic        exc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [3:0]  rreq = '0, xreq = '0;
    logic        ack, exc;
    logic [31:0] rdata;
    logic [3:0]  halt_ack, res_ack, exe_ack;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t q[$];

    // model of the per-hart flags, from the requirements
    logic [3:0] m_res = '0, m_exe = '0;

    always #10 clk = ~clk;   // 50 MHz

    dbg_req_ack_regs uut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .bus_req_i       (req),
        .bus_we_i        (we),
        .bus_addr_i      (addr),
        .bus_wdata_i     (wdata),
        .bus_ack_o       (ack),
        .bus_rdata_o     (rdata),
        .dm_resume_req_i (rreq),
        .dm_exec_req_i   (xreq),
        .dm_halt_ack_o   (halt_ack),
        .dm_resume_ack_o (res_ack),
        .dm_exec_ack_o   (exe_ack),
        .dm_exc_ack_o    (exc)
    );

    function automatic logic [31:0] image(input logic [3:0] r, input logic [3:0] x);
        logic [31:0] v = '0;
        for (int i = 0; i < 4; i++) v[i*8 +: 2] = {x[i], r[i]};
        return v;
    endfunction

    // driver: one bus cycle plus request pulses, pushes the expected outputs
    task automatic step(input bit rq, input bit w, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] sr,
                        input logic [3:0] sx, input string tag);
        exp_t e;
        bit   inwin;
        logic [1:0] slot;
        logic [3:0] sel;
        @(negedge clk);
        req = rq; we = w; addr = a; wdata = d; rreq = sr; xreq = sx;
        inwin = rq && (a[31:4] == BASE[31:4]);
        slot  = a[3:2];
        sel   = 4'b0001 << d[1:0];
        e.tag   = tag;
        e.ack   = inwin;
        e.rdata = (inwin && !w && slot == 2'd0) ? image(m_res, m_exe) : 32'h0;
        e.halt  = (inwin && w && slot == 2'd0) ? sel : 4'h0;
        e.res   = (inwin && w && slot == 2'd1) ? sel : 4'h0;
        e.exe   = (inwin && w && slot == 2'd2) ? sel : 4'h0;
        e.exc   = inwin && w && slot == 2'd3;
        q.push_back(e);
        m_res = (m_res & ~e.res) | sr;
        m_exe = (m_exe & ~e.exe) | sx;
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        step(1, 0, a, 32'h0, 4'h0, 4'h0, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
        step(1, 1, a, d, 4'h0, 4'h0, tag);
    endtask

    // monitor: compares one expected item per cycle, away from the edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (ack !== e.ack || rdata !== e.rdata || halt_ack !== e.halt ||
                res_ack !== e.res || exe_ack !== e.exe || exc !== e.exc) begin
                fails++;
                $display("FAIL %s: actual ack=%b rdata=%h halt=%b res=%b exe=%b exc=%b expected ack=%b rdata=%h halt=%b res=%b exe=%b exc=%b",
                         e.tag, ack, rdata, halt_ack, res_ack, exe_ack, exc,
                         e.ack, e.rdata, e.halt, e.res, e.exe, e.exc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (ack !== 1'b0 || rdata !== 32'h0 || halt_ack !== 4'h0 || res_ack !== 4'h0 ||
            exe_ack !== 4'h0 || exc !== 1'b0) begin
            fails++;
            $display("FAIL reset R2: actual ack=%b rdata=%h expected all zero", ack, rdata);
        end
        rst_n = 1'b1;

        rd(BASE, "R3 empty flags");
        step(0, 0, 32'h0, 32'h0, 4'b0010, 4'b0100, "R5 R6 request pulses");
        step(0, 0, 32'h0, 32'h0, 4'h0, 4'h0, "R1 idle cycle");
        rd(BASE,      "R3 R5 R6 flags held");
        rd(BASE + 2,  "R3 byte address selects same word");
        rd(BASE + 3,  "R3 top byte address");
        rd(BASE + 4,  "R4 read slot 1 zero");
        rd(BASE + 8,  "R4 read slot 2 zero");
        rd(BASE + 12, "R4 read slot 3 zero");
        wr(BASE, 32'h3, "R7 halt ack hart 3");
        rd(BASE, "R7 flags unchanged by halt ack");
        wr(BASE + 4, 32'h1, "R8 resume ack hart 1");
        rd(BASE, "R8 resume flag cleared");
        wr(BASE + 4, 32'h0, "R8 resume ack hart 0 with no flag");
        wr(BASE + 8, 32'h2, "R9 exec ack hart 2");
        rd(BASE, "R9 exec flag cleared");
        wr(BASE + 12, 32'hDEAD_BEEF, "R10 exception ack any data");
        wr(BASE + 13, 32'h0, "R10 exception ack unaligned low bits");

        // outside the window: neither ack nor flag change
        step(0, 0, 32'h0, 32'h0, 4'b0001, 4'b1000, "R5 R6 set hart 0 resume hart 3 exec");
        wr(32'hFFFF_FF7C, 32'h0, "R1 write below window");
        wr(32'hFFFF_FF94, 32'h0, "R1 write above window");
        wr(32'h0000_0088, 32'h3, "R1 write aliased low address");
        rd(32'hFFFF_FF90, "R1 read above window");
        rd(BASE, "R1 flags intact after outside writes");

        // set and clear on the same edge
        step(1, 1, BASE + 4, 32'h0, 4'b0001, 4'b0000, "R11 resume set and ack together");
        step(1, 1, BASE + 8, 32'h3, 4'b0000, 4'b1000, "R11 exec set and ack together");
        rd(BASE, "R11 flags survive");

        step(0, 0, 32'h0, 32'h0, 4'hF, 4'hF, "R5 R6 all harts");
        rd(BASE, "R3 all flags set");
        for (int h = 0; h < 4; h++) wr(BASE + 4, 32'(h), "R8 clear resume each hart");
        rd(BASE, "R8 only exec flags remain");
        for (int h = 0; h < 4; h++) wr(BASE + 8, 32'(h) | 32'hFFFF_FF00, "R9 clear exec upper data ignored");
        rd(BASE, "R9 all flags clear");
        step(0, 0, 32'h0, 32'h0, 4'h0, 4'h0, "R10 no pulse after idle");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule